// File: doc/BRIEF.md
# Paged SPI Register Window

This block is the serial-slave front end of a register space that is organised in 256-byte pages. An SPI master, using mode 0 with the most significant bit first, sends frames. A frame is one command byte, then one offset byte, then any number of data bytes. Three offsets at the top of the page are claimed by the block itself: a page register, a status register and a read data window. Every other offset is forwarded to the internal register fabric.

Writes to a forwarded offset are collected while chip select is low. They leave the block as one request when chip select rises, with a byte count as the width. Reads are split into two phases. A read frame to a forwarded offset only starts an internal fetch of a full word and marks the block busy. When the fabric answers, the word is kept and an acknowledge bit is raised. The master polls the status register, then streams the word out of the data window, lowest byte first. The SPI pins are oversampled by the system clock through synchronisers, so the serial clock must be much slower than the system clock.

Top module: `spi_page_window`

## Requirements
- R1: A frame is acted upon only if its first byte has bits 7:1 equal to 0110000b; bit 0 selects write (1) or read (0). Any other first byte makes the whole frame a no-op: no request, no register change, and all reply bytes are zero.
- R2: A write frame to offset 0xFF stores its first data byte as the current page and ignores later data bytes. A read frame to 0xFF returns the current page in every reply byte. The page resets to 0x00.
- R3: A read frame to offset 0xFE returns the status byte in every reply byte. Bit 7 is busy, bit 5 is the read acknowledge, and all other bits are 0. Status resets to 0x00.
- R4: A read frame to any offset other than 0xF0, 0xFE and 0xFF, when not busy, issues exactly one `req_rd` pulse. The pulse carries the current page, the offset, and a width of DATA_BYTES. It also sets busy and clears any earlier acknowledge.
- R5: A read frame to a forwarded offset while busy issues no request.
- R6: On `rd_ready` while busy, the block keeps `rd_data`, clears busy and sets the acknowledge.
- R7: A read frame to offset 0xF0 returns the kept word, lowest byte first, and zero for bytes beyond DATA_BYTES. It clears the acknowledge.
- R8: A write frame to a forwarded offset with n ≥ 1 data bytes issues one `req_wr` after chip select rises. The request has width min(n, DATA_BYTES), the page and offset, and `req_wdata` holding the first bytes with the first byte in the lowest byte lane and unused lanes zero. With n = 0 no request is issued.
- R9: Write frames to 0xFE and 0xF0 change nothing and issue no request.
- R10: `spi_miso_oe` is 1 exactly while `spi_cs_n` is low, and `spi_miso` is 0 whenever it is not driven. Reply bytes start with the third byte of a frame and are shifted out most significant bit first. The data changes on the falling serial clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master (idle low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial reply data |
| spi_miso_oe | output | 1 | Output enable for the reply pin |
| req_rd | output | 1 | One-cycle internal read request |
| req_wr | output | 1 | One-cycle internal write request |
| req_page | output | 8 | Page of the request |
| req_offset | output | 8 | Offset of the request |
| req_width | output | $clog2(DATA_BYTES+1) | Number of bytes in the request |
| req_wdata | output | 8*DATA_BYTES | Write data, first byte in the lowest lane |
| rd_ready | input | 1 | Fabric answer strobe for a read |
| rd_data | input | 8*DATA_BYTES | Fetched word, lowest byte first |

## Verification
On every cycle, the assertions check the following. No read request appears while a fetch is outstanding. A launch always leaves busy set, the acknowledge clear and a full width. An answer always clears busy, and the acknowledge rises only after an answer. A write request comes only right after chip select rises and carries a width between one and DATA_BYTES. A received byte always follows a serial clock rise. The values themselves can only be shown by the bench's scenarios: the page and status replies, the byte order out of the window and into the write data, the zero fill, the width clipping, the ignored frames, and the stale acknowledge cleared by a new fetch. The bench sweeps write lengths from 0 to 9 and reads over several pages and offsets, and compares against an arithmetic register model.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam logic [7:0] OFS_PAGE   = 8'hFF;
    localparam logic [7:0] OFS_STATUS = 8'hFE;
    localparam logic [7:0] OFS_WINDOW = 8'hF0;
    localparam logic [6:0] CMD_TAG    = 7'b0110000;
    localparam int         ST_BUSY    = 7;
    localparam int         ST_ACK     = 5;

    typedef enum logic [2:0] {
        FK_NONE,
        FK_PAGE,
        FK_STATUS,
        FK_WINDOW,
        FK_REG
    } frame_kind_t;

    typedef struct packed {
        frame_kind_t kind;
        logic        is_wr;
        logic        cmd_ok;
        logic [7:0]  offset;
    } frame_t;

    function automatic frame_kind_t classify(input logic [7:0] ofs);
        if (ofs == OFS_PAGE)        return FK_PAGE;
        else if (ofs == OFS_STATUS) return FK_STATUS;
        else if (ofs == OFS_WINDOW) return FK_WINDOW;
        else                        return FK_REG;
    endfunction

    function automatic logic [7:0] status_byte(input logic busy, input logic ack);
        logic [7:0] s;
        s = 8'h00;
        s[ST_BUSY] = busy;
        s[ST_ACK]  = ack;
        return s;
    endfunction

endpackage

// File: rtl/spw_sync.sv
module spw_sync #(
    parameter int                STAGES = 2,
    parameter int                WIDTH  = 3,
    parameter logic [WIDTH-1:0]  INIT   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{INIT}};
        else     pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spw_shifter.sv
module spw_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       cs_n_s,
    input  logic       mosi_s,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       tx_msb
);
    logic       sclk_q, cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       sclk_rise, sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_q & ~cs_n_s;
    assign sclk_fall = ~sclk_s & sclk_q & ~cs_n_s;
    assign cs_fall   = cs_q & ~cs_n_s;
    assign cs_rise   = ~cs_q & cs_n_s;
    assign tx_msb    = tx_sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            sclk_q   <= sclk_s;
            cs_q     <= cs_n_s;
            rx_valid <= 1'b0;
            if (cs_fall || cs_rise) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (sclk_rise) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    rx_sh   <= {rx_sh[5:0], mosi_s};
                    if (bit_cnt == 3'd7) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= {rx_sh, mosi_s};
                    end
                end
                if (tx_load)
                    tx_sh <= tx_byte;
                else if (sclk_fall && bit_cnt != 3'd0)
                    tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    a_r10_rx_follows_rise: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(sclk_rise));
endmodule

// File: rtl/spw_frame_ctrl.sv
module spw_frame_ctrl
    import spw_pkg::*;
#(
    parameter  int NBYTES = 8,
    localparam int WW     = $clog2(NBYTES + 1),
    localparam int IW     = $clog2(NBYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    output logic                tx_load,
    output logic [7:0]          tx_byte,
    output logic                req_rd,
    output logic                req_wr,
    output logic [7:0]          req_page,
    output logic [7:0]          req_offset,
    output logic [WW-1:0]       req_width,
    output logic [NBYTES*8-1:0] req_wdata,
    input  logic                rd_ready,
    input  logic [NBYTES*8-1:0] rd_data
);
    frame_t        fr;
    frame_kind_t   rx_kind;
    logic [1:0]    phase;
    logic [7:0]    page_q;
    logic          busy, ack;
    logic [7:0]    fbuf [NBYTES];
    logic [7:0]    wbuf [NBYTES];
    logic [7:0]    rd_bytes [NBYTES];
    logic [NBYTES*8-1:0] wpacked;
    logic [WW-1:0] wcount, rptr;

    assign rx_kind = classify(rx_byte);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign rd_bytes[i]       = rd_data[8*i +: 8];
        assign wpacked[8*i +: 8] = wbuf[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr         <= '{kind: FK_NONE, is_wr: 1'b0, cmd_ok: 1'b0, offset: 8'h00};
            phase      <= '0;
            page_q     <= '0;
            busy       <= 1'b0;
            ack        <= 1'b0;
            wcount     <= '0;
            rptr       <= '0;
            tx_load    <= 1'b0;
            tx_byte    <= '0;
            req_rd     <= 1'b0;
            req_wr     <= 1'b0;
            req_page   <= '0;
            req_offset <= '0;
            req_width  <= '0;
            req_wdata  <= '0;
            for (int i = 0; i < NBYTES; i++) begin
                fbuf[i] <= '0;
                wbuf[i] <= '0;
            end
        end else begin
            tx_load <= 1'b0;
            req_rd  <= 1'b0;
            req_wr  <= 1'b0;

            if (rd_ready && busy) begin
                for (int i = 0; i < NBYTES; i++) fbuf[i] <= rd_bytes[i];
                busy <= 1'b0;
                ack  <= 1'b1;
            end

            if (cs_fall) begin
                fr     <= '{kind: FK_NONE, is_wr: 1'b0, cmd_ok: 1'b0, offset: 8'h00};
                phase  <= '0;
                wcount <= '0;
                rptr   <= '0;
                for (int i = 0; i < NBYTES; i++) wbuf[i] <= '0;
            end else if (cs_rise) begin
                if (fr.cmd_ok && fr.is_wr && fr.kind == FK_REG && wcount != '0) begin
                    req_wr     <= 1'b1;
                    req_page   <= page_q;
                    req_offset <= fr.offset;
                    req_width  <= wcount;
                    req_wdata  <= wpacked;
                end
            end else if (rx_valid) begin
                tx_load <= 1'b1;
                tx_byte <= 8'h00;
                case (phase)
                    2'd0: begin
                        fr.cmd_ok <= (rx_byte[7:1] == CMD_TAG);
                        fr.is_wr  <= rx_byte[0];
                        phase     <= 2'd1;
                    end
                    2'd1: begin
                        phase     <= 2'd2;
                        fr.offset <= rx_byte;
                        fr.kind   <= fr.cmd_ok ? rx_kind : FK_NONE;
                        if (fr.cmd_ok && !fr.is_wr) begin
                            case (rx_kind)
                                FK_PAGE:   tx_byte <= page_q;
                                FK_STATUS: tx_byte <= status_byte(busy, ack);
                                FK_WINDOW: begin
                                    tx_byte <= fbuf[0];
                                    rptr    <= WW'(1);
                                    ack     <= 1'b0;
                                end
                                FK_REG: begin
                                    if (!busy) begin
                                        req_rd     <= 1'b1;
                                        req_page   <= page_q;
                                        req_offset <= rx_byte;
                                        req_width  <= WW'(NBYTES);
                                        busy       <= 1'b1;
                                        ack        <= 1'b0;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                    default: begin
                        if (fr.is_wr) begin
                            if (fr.kind == FK_PAGE && wcount == '0)
                                page_q <= rx_byte;
                            if (wcount != WW'(NBYTES)) begin
                                wbuf[wcount[IW-1:0]] <= rx_byte;
                                wcount <= wcount + WW'(1);
                            end
                        end else begin
                            case (fr.kind)
                                FK_PAGE:   tx_byte <= page_q;
                                FK_STATUS: tx_byte <= status_byte(busy, ack);
                                FK_WINDOW: begin
                                    if (rptr < WW'(NBYTES)) begin
                                        tx_byte <= fbuf[rptr[IW-1:0]];
                                        rptr    <= rptr + WW'(1);
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    a_r5_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !req_rd);
    a_r4_launch_state: assert property (@(posedge clk) disable iff (rst)
        req_rd |-> (busy && !ack && req_width == WW'(NBYTES)));
    a_r6_answer_clears_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_ready) |=> !busy);
    a_r6_ack_needs_answer: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(rd_ready));
    a_r8_write_after_cs: assert property (@(posedge clk) disable iff (rst)
        req_wr |-> ($past(cs_rise) && req_width != '0 && req_width <= WW'(NBYTES)));
endmodule

// File: rtl/spi_page_window.sv
module spi_page_window #(
    parameter  int DATA_BYTES  = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int WW          = $clog2(DATA_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spi_sclk,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    spi_miso_oe,
    output logic                    req_rd,
    output logic                    req_wr,
    output logic [7:0]              req_page,
    output logic [7:0]              req_offset,
    output logic [WW-1:0]           req_width,
    output logic [DATA_BYTES*8-1:0] req_wdata,
    input  logic                    rd_ready,
    input  logic [DATA_BYTES*8-1:0] rd_data
);
    logic [2:0] pins_s;
    logic       rx_valid, cs_fall, cs_rise, tx_load, tx_msb;
    logic [7:0] rx_byte, tx_byte;

    spw_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .INIT(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   (pins_s)
    );

    spw_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (pins_s[2]),
        .cs_n_s   (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .tx_msb   (tx_msb)
    );

    spw_frame_ctrl #(.NBYTES(DATA_BYTES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .tx_load    (tx_load),
        .tx_byte    (tx_byte),
        .req_rd     (req_rd),
        .req_wr     (req_wr),
        .req_page   (req_page),
        .req_offset (req_offset),
        .req_width  (req_width),
        .req_wdata  (req_wdata),
        .rd_ready   (rd_ready),
        .rd_data    (rd_data)
    );

    assign spi_miso_oe = ~spi_cs_n;
    assign spi_miso    = ~spi_cs_n & tx_msb;
endmodule

// File: tb/spi_page_window_tb.sv
module spi_page_window_tb;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic          spi_miso, spi_miso_oe;
    logic          req_rd, req_wr;
    logic [7:0]    req_page, req_offset;
    logic [3:0]    req_width;
    logic [63:0]   req_wdata;
    logic          rd_ready = 1'b0;
    logic [63:0]   rd_data  = '0;

    spi_page_window u_dut (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .req_rd(req_rd), .req_wr(req_wr), .req_page(req_page),
        .req_offset(req_offset), .req_width(req_width), .req_wdata(req_wdata),
        .rd_ready(rd_ready), .rd_data(rd_data)
    );

    int total = 0, bad = 0;
    int rd_cnt = 0, wr_cnt = 0, pend = 0, rsp_delay = 6;
    logic [7:0]  rq_page, rq_off;
    logic [3:0]  rq_width;
    logic [7:0]  wq_page, wq_off;
    logic [3:0]  wq_width;
    logic [63:0] wq_data;
    logic [7:0]  tx_b [16];
    logic [7:0]  rx_b [16];
    bit          oe_seen;

    function automatic logic [63:0] model(input logic [7:0] pg, input logic [7:0] of);
        logic [63:0] v;
        for (int i = 0; i < NB; i++) v[8*i +: 8] = 8'(pg * 3 + of + i * 17);
        return v;
    endfunction

    // memory model of the register fabric
    always @(negedge clk) begin
        rd_ready = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rd_ready = 1'b1;
                rd_data  = model(rq_page, rq_off);
            end
        end
        if (req_rd) begin
            rd_cnt++;
            rq_page = req_page; rq_off = req_offset; rq_width = req_width;
            pend = rsp_delay;
        end
        if (req_wr) begin
            wr_cnt++;
            wq_page = req_page; wq_off = req_offset;
            wq_width = req_width; wq_data = req_wdata;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic xfer(input int n);
        spi_cs_n = 1'b0;
        oe_seen = 1'b0;
        for (int b = 0; b < n; b++) begin
            for (int k = 7; k >= 0; k--) begin
                spi_mosi = tx_b[b][k];
                repeat (8) @(negedge clk);
                rx_b[b][k] = spi_miso;
                if (spi_miso_oe) oe_seen = 1'b1;
                spi_sclk = 1'b1;
                repeat (8) @(negedge clk);
                spi_sclk = 1'b0;
            end
        end
        repeat (8) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic frame3(input logic [7:0] c, input logic [7:0] o, input logic [7:0] d);
        tx_b[0] = c; tx_b[1] = o; tx_b[2] = d;
        xfer(3);
    endtask

    task automatic read_status(output logic [7:0] s);
        frame3(8'h60, 8'hFE, 8'h00);
        s = rx_b[2];
    endtask

    task automatic set_page(input logic [7:0] p);
        frame3(8'h61, 8'hFF, p);
    endtask

    logic [63:0] exp_w;
    logic [7:0]  st;
    int          rc, wc;

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // reset state
        check("R10 oe low while idle", spi_miso_oe, 0);
        check("R10 miso low while idle", spi_miso, 0);
        read_status(st);
        check("R3 status after reset", st, 8'h00);
        check("R10 oe during frame", oe_seen, 1);
        check("R10 oe after frame", spi_miso_oe, 0);
        frame3(8'h60, 8'hFF, 8'h00);
        check("R2 page after reset", rx_b[2], 8'h00);

        // page write keeps first byte only, read returns it in every byte
        tx_b[0] = 8'h61; tx_b[1] = 8'hFF; tx_b[2] = 8'h12; tx_b[3] = 8'h99;
        xfer(4);
        tx_b[0] = 8'h60; tx_b[1] = 8'hFF; tx_b[2] = 0; tx_b[3] = 0; tx_b[4] = 0;
        xfer(5);
        check("R2 page multi byte read", {rx_b[2], rx_b[3], rx_b[4]}, 24'h121212);

        // write length sweep 0..9
        for (int len = 0; len <= 9; len++) begin
            wc = wr_cnt;
            tx_b[0] = 8'h61; tx_b[1] = 8'(8'h10 + len);
            exp_w = '0;
            for (int i = 0; i < len; i++) begin
                tx_b[2 + i] = 8'(8'h10 + len + i * 5 + len * 16);
                if (i < NB) exp_w[8*i +: 8] = tx_b[2 + i];
            end
            xfer(2 + len);
            if (len == 0) begin
                check("R8 empty write no request", wr_cnt - wc, 0);
            end else begin
                check("R8 one write request", wr_cnt - wc, 1);
                check("R8 write width", wq_width, (len > NB) ? NB : len);
                check("R8 write data lanes", wq_data, exp_w);
                check("R8 write page/offset", {wq_page, wq_off}, {8'h12, 8'(8'h10 + len)});
            end
        end

        // writes to status and window are ignored
        wc = wr_cnt;
        frame3(8'h61, 8'hFE, 8'hFF);
        frame3(8'h61, 8'hF0, 8'hAA);
        check("R9 no request for special writes", wr_cnt - wc, 0);
        read_status(st);
        check("R9 status unchanged", st, 8'h00);
        frame3(8'h60, 8'hF0, 8'h00);
        check("R9 window unchanged", rx_b[2], 8'h00);

        // malformed commands are no-ops
        rc = rd_cnt; wc = wr_cnt;
        frame3(8'h11, 8'hFF, 8'h33);
        frame3(8'hE1, 8'hFF, 8'h44);
        frame3(8'h70, 8'h20, 8'h00);
        frame3(8'hE0, 8'hFE, 8'h00);
        check("R1 bad command reply zero", rx_b[2], 8'h00);
        check("R1 bad command no requests", {rd_cnt - rc, wr_cnt - wc}, 0);
        frame3(8'h60, 8'hFF, 8'h00);
        check("R1 page kept after bad command", rx_b[2], 8'h12);

        // read sweep over pages and offsets
        for (int p = 0; p < 4; p++) begin
            logic [7:0] pg, of;
            pg = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h5A : 8'hFE;
            of = (p == 0) ? 8'h00 : (p == 1) ? 8'h37 : (p == 2) ? 8'hEF : 8'hF1;
            set_page(pg);
            rc = rd_cnt;
            tx_b[0] = 8'h60; tx_b[1] = of;
            xfer(2);
            repeat (40) @(negedge clk);
            check("R4 one read request", rd_cnt - rc, 1);
            check("R4 read request fields", {rq_page, rq_off, rq_width}, {pg, of, 4'd8});
            read_status(st);
            check("R6 ack after answer", st, 8'h20);
            tx_b[0] = 8'h60; tx_b[1] = 8'hF0;
            for (int i = 2; i < 12; i++) tx_b[i] = 8'h00;
            xfer(12);
            check("R7 window bytes", {rx_b[9], rx_b[8], rx_b[7], rx_b[6],
                                       rx_b[5], rx_b[4], rx_b[3], rx_b[2]}, model(pg, of));
            check("R7 window tail zero", {rx_b[10], rx_b[11]}, 16'h0000);
            read_status(st);
            check("R7 ack cleared by window", st, 8'h00);
        end

        // stale acknowledge, busy and dropped read
        set_page(8'h33);
        tx_b[0] = 8'h60; tx_b[1] = 8'h22; xfer(2);
        repeat (40) @(negedge clk);
        read_status(st);
        check("R6 ack set before new fetch", st, 8'h20);
        rsp_delay = 3000;
        tx_b[0] = 8'h60; tx_b[1] = 8'h23; xfer(2);
        read_status(st);
        check("R4 busy set and stale ack cleared", st, 8'h80);
        rc = rd_cnt;
        tx_b[0] = 8'h60; tx_b[1] = 8'h24; xfer(2);
        check("R5 no request while busy", rd_cnt - rc, 0);
        repeat (3500) @(negedge clk);
        read_status(st);
        check("R6 busy cleared ack set", st, 8'h20);
        tx_b[0] = 8'h60; tx_b[1] = 8'hF0;
        for (int i = 2; i < 10; i++) tx_b[i] = 8'h00;
        xfer(10);
        check("R6 window holds answered word", {rx_b[9], rx_b[8], rx_b[7], rx_b[6],
                                                rx_b[5], rx_b[4], rx_b[3], rx_b[2]}, model(8'h33, 8'h23));

        summary();
    end
endmodule